// File: doc/BRIEF.md
# PWM/PFM Mode Transition Controller

This block chooses, for one power channel, between fixed-frequency PWM regulation and a light-load pulse-frequency mode (PFM). On every switching-frequency tick it compares the digitized inductor current with a programmable threshold and counts how many ticks in a row the current has been below it. When that run reaches a programmable length, a set/reset mode latch switches the channel to PFM. The PWM loop is then held disabled and the channel regulates from comparator flags.

In PFM, each time the output drops under the reference, the block issues a single-clock trigger that starts one switching cycle. It issues no further trigger until the power stage reports that the cycle is done. A trigger is withheld while the output sits above the upper window edge. When the output falls below the lower window edge, the latch returns the channel to PWM. When PFM is entered, the block stores the PWM duty cycle of that moment so the first PFM pulses keep the ripple of the PWM steady state. The comparators and the current converter stay outside the block; only their digital results arrive here.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: After reset the channel is in PWM: `pfm_mode`=0, `pwm_loop_dis`=0, `trig`=0, `pfm_duty`=0. The run-length register holds 20.
- R2: A tick with `i_meas` < `i_thresh` adds one to the low-current run. On the clock edge of the tick that makes the run equal to the stored length, `pfm_mode` becomes 1 and is visible in the following cycle. Cycles without `sw_tick` leave the run unchanged.
- R3: A tick with `i_meas` >= `i_thresh` (equality included) clears the run to zero. Entry then needs a full new run.
- R4: A one-cycle `cfg_wr` loads `cfg_cycles` into the run-length register. A stored length of 0 behaves as 1.
- R5: `pwm_loop_dis` is 1 exactly while `pfm_mode` is 1.
- R6: In PFM, `v_below_low`=1 returns the channel to PWM at the next edge. The run starts again from zero after the exit.
- R7: In PFM, `v_below_ref`=1 produces `trig`=1 for exactly one clock, in the cycle after the flag is sampled.
- R8: After a trigger, no further trigger is issued until `cycle_done` has been seen. A trigger may follow in the cycle after the edge that samples `cycle_done`. A `cycle_done` with no cycle outstanding has no effect.
- R9: No trigger is issued while `v_above_high`=1.
- R10: When `v_below_low` and `v_below_ref` are both 1 in PFM, the exit wins and no trigger is issued.
- R11: On entry to PFM, `pfm_duty` takes the `pwm_duty` value present on the entry edge. It holds that value for the whole stay in PFM.
- R12: In PWM the comparator flags have no effect: there is no trigger and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the run-length register |
| cfg_cycles | input | CW (8) | New run length |
| i_thresh | input | IW (8) | Light-load current threshold |
| i_meas | input | IW (8) | Digitized inductor current |
| sw_tick | input | 1 | One-clock pulse per switching period |
| v_below_ref | input | 1 | Output below reference |
| v_below_low | input | 1 | Output below lower window edge |
| v_above_high | input | 1 | Output above upper window edge |
| cycle_done | input | 1 | Power stage finished the triggered cycle |
| pwm_duty | input | DW (8) | Present steady-state PWM duty |
| pfm_mode | output | 1 | 1 = PFM, 0 = PWM |
| pwm_loop_dis | output | 1 | Disables the PWM control loop |
| trig | output | 1 | Starts one PFM switching cycle |
| pfm_duty | output | DW (8) | Duty captured on PFM entry |

## Verification
The exit request and the trigger request can arise in the same cycle, because an output below the lower edge is also below the reference. The bench raises both flags together while in PFM. It then expects PWM in the next cycle and no trigger pulse at any point. A second collision is a `cycle_done` in the same cycle as a pending reference crossing. That cycle must give no pulse, and the pulse must appear exactly one cycle later.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int unsigned CYCLES_RST = 20;

  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PFM = 1'b1
  } mode_e;
endpackage

// File: rtl/lowload_counter.sv
module lowload_counter #(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [IW-1:0] meas_i,
  input  logic [IW-1:0] thresh_i,
  input  logic [CW-1:0] limit_i,
  input  logic          in_pfm_i,
  output logic          set_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          is_low;

  always_comb begin
    is_low  = meas_i < thresh_i;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    set_o   = tick_i && is_low && !in_pfm_i && (cnt_inc >= {1'b0, limit_i});
    cnt_d   = cnt_q;
    if (in_pfm_i || set_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = is_low ? cnt_inc[CW-1:0] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !in_pfm_i) |=> $stable(cnt_q)) else $error("count moved without tick"); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !is_low) |=> (cnt_q == '0)) else $error("count not cleared"); // R3
endmodule

// File: rtl/mode_latch.sv
module mode_latch
  import pfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic below_low_i,
  output logic in_pfm_o
);
  mode_e mode_q, mode_d;
  logic  clr;

  always_comb begin
    clr    = (mode_q == MODE_PFM) && below_low_i;
    mode_d = mode_q;
    if (set_i)    mode_d = MODE_PFM;
    else if (clr) mode_d = MODE_PWM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_PWM;
    else        mode_q <= mode_d;
  end

  assign in_pfm_o = (mode_q == MODE_PFM);

  AST_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pfm_o && below_low_i) |=> !in_pfm_o) else $error("no exit"); // R6
  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pfm_o && !set_i) |=> !in_pfm_o) else $error("spurious entry"); // R12
endmodule

// File: rtl/pfm_trigger.sv
module pfm_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pfm_i,
  input  logic below_ref_i,
  input  logic below_low_i,
  input  logic above_high_i,
  input  logic cycle_done_i,
  output logic trig_o
);
  logic trig_q, trig_d;
  logic busy_q, busy_d;
  logic fire;

  always_comb begin
    fire   = in_pfm_i && below_ref_i && !above_high_i && !below_low_i && !busy_q;
    trig_d = fire;
    busy_d = busy_q;
    if (!in_pfm_i)         busy_d = 1'b0;
    else if (fire)         busy_d = 1'b1;
    else if (cycle_done_i) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
      busy_q <= busy_d;
    end
  end

  assign trig_o = trig_q;

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o) else $error("trigger longer than one clock"); // R7
  AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cycle_done_i) |=> !trig_o) else $error("retrigger while busy"); // R8
  AST_TRIG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    above_high_i |=> !trig_o) else $error("trigger above window"); // R9
  AST_TRIG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    below_low_i |=> !trig_o) else $error("trigger on exit"); // R10
  AST_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> in_pfm_i) else $error("trigger outside PFM"); // R12
endmodule

// File: rtl/duty_hold.sv
module duty_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          in_pfm_i,
  input  logic [DW-1:0] duty_i,
  output logic [DW-1:0] duty_o
);
  logic [DW-1:0] duty_q;
  logic          cap_en;

  assign cap_en = set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      duty_q <= '0;
    else if (cap_en) duty_q <= duty_i;
  end

  assign duty_o = duty_q;

  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pfm_i) |-> (duty_o == $past(duty_i))) else $error("duty not captured"); // R11
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pfm_i && $past(in_pfm_i)) |-> $stable(duty_o)) else $error("duty moved in PFM"); // R11
endmodule

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl
  import pfm_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_cycles,
  input  logic [IW-1:0] i_thresh,
  input  logic [IW-1:0] i_meas,
  input  logic          sw_tick,
  input  logic          v_below_ref,
  input  logic          v_below_low,
  input  logic          v_above_high,
  input  logic          cycle_done,
  input  logic [DW-1:0] pwm_duty,
  output logic          pfm_mode,
  output logic          pwm_loop_dis,
  output logic          trig,
  output logic [DW-1:0] pfm_duty
);
  localparam logic [CW-1:0] LIMIT_RST = CW'(CYCLES_RST);

  logic [CW-1:0] limit_q;
  logic          set_pfm;
  logic          in_pfm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit_q <= LIMIT_RST;
    else if (cfg_wr) limit_q <= cfg_cycles;
  end

  lowload_counter #(.IW(IW), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (sw_tick),
    .meas_i   (i_meas),
    .thresh_i (i_thresh),
    .limit_i  (limit_q),
    .in_pfm_i (in_pfm),
    .set_o    (set_pfm)
  );

  mode_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (set_pfm),
    .below_low_i (v_below_low),
    .in_pfm_o    (in_pfm)
  );

  pfm_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_pfm_i     (in_pfm),
    .below_ref_i  (v_below_ref),
    .below_low_i  (v_below_low),
    .above_high_i (v_above_high),
    .cycle_done_i (cycle_done),
    .trig_o       (trig)
  );

  duty_hold #(.DW(DW)) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_pfm),
    .in_pfm_i (in_pfm),
    .duty_i   (pwm_duty),
    .duty_o   (pfm_duty)
  );

  assign pfm_mode     = in_pfm;
  assign pwm_loop_dis = in_pfm;

  AST_ENTRY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_mode) |-> $past(sw_tick && (i_meas < i_thresh))) else $error("entry without low tick"); // R2
endmodule

// File: tb/pfm_mode_ctrl_test.sv
`timescale 1ns/1ps
module pfm_mode_ctrl_test;
  localparam int IW = 8, CW = 8, DW = 8;
  localparam logic [IW-1:0] THR = 8'd40;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [CW-1:0] cfg_cycles;
  logic [IW-1:0] i_thresh, i_meas;
  logic sw_tick, v_below_ref, v_below_low, v_above_high, cycle_done;
  logic [DW-1:0] pwm_duty;
  logic pfm_mode, pwm_loop_dis, trig;
  logic [DW-1:0] pfm_duty;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  pfm_mode_ctrl #(.IW(IW), .CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cycles(cfg_cycles),
    .i_thresh(i_thresh), .i_meas(i_meas), .sw_tick(sw_tick),
    .v_below_ref(v_below_ref), .v_below_low(v_below_low),
    .v_above_high(v_above_high), .cycle_done(cycle_done),
    .pwm_duty(pwm_duty), .pfm_mode(pfm_mode), .pwm_loop_dis(pwm_loop_dis),
    .trig(trig), .pfm_duty(pfm_duty)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_tick(input logic [IW-1:0] cur);
    i_meas  = cur;
    sw_tick = 1'b1;
    step();
    sw_tick = 1'b0;
    i_meas  = 8'd200;
  endtask

  task automatic leave_pfm();
    v_below_low = 1'b1;
    v_below_ref = 1'b1;
    step();
    check("R10 exit wins no trig", trig, 0);
    check("R6 exit to PWM", pfm_mode, 0);
    v_below_low = 1'b0;
    v_below_ref = 1'b0;
    step();
    check("R10 no late trig", trig, 0);
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_cycles = '0; i_thresh = THR; i_meas = 8'd200;
    sw_tick = 1'b0; v_below_ref = 1'b0; v_below_low = 1'b0; v_above_high = 1'b0;
    cycle_done = 1'b0; pwm_duty = 8'h5A;
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 mode", pfm_mode, 0);
    check("R1 loop dis", pwm_loop_dis, 0);
    check("R1 trig", trig, 0);
    check("R1 duty", pfm_duty, 0);

    // R12: comparator flags in PWM have no effect
    v_below_ref = 1'b1; v_below_low = 1'b1;
    step(); step();
    check("R12 no trig in PWM", trig, 0);
    check("R12 mode stays PWM", pfm_mode, 0);
    v_below_ref = 1'b0; v_below_low = 1'b0;

    // R1/R2: default run length 20, idle cycles between ticks keep the run
    for (int t = 1; t <= 20; t++) begin
      do_tick(8'd39);
      check(t == 20 ? "R1 default 20 entry" : "R2 before run end", pfm_mode, t == 20 ? 1 : 0);
      i_meas = 8'd0;
      step();
      check("R2 no tick no change", pfm_mode, t == 20 ? 1 : 0);
    end
    check("R5 loop disabled", pwm_loop_dis, 1);
    check("R11 duty captured", pfm_duty, 8'h5A);
    pwm_duty = 8'h21;
    step();
    check("R11 duty held", pfm_duty, 8'h5A);

    // R7/R8: trigger pulse and busy hold
    v_below_ref = 1'b1;
    step();
    check("R7 trig pulse", trig, 1);
    step();
    check("R7 pulse one clock", trig, 0);
    step(); step();
    check("R8 no retrig while busy", trig, 0);
    cycle_done = 1'b1;
    step();
    check("R8 no trig on done edge", trig, 0);
    cycle_done = 1'b0;
    step();
    check("R8 trig after done", trig, 1);
    v_below_ref = 1'b0;
    cycle_done = 1'b1;
    step();
    cycle_done = 1'b0;
    // R8: extra done with nothing outstanding
    cycle_done = 1'b1;
    step();
    cycle_done = 1'b0;
    check("R8 stray done no trig", trig, 0);
    // R9: suppressed above high window
    v_above_high = 1'b1; v_below_ref = 1'b1;
    step(); step();
    check("R9 suppressed above high", trig, 0);
    v_above_high = 1'b0;
    step();
    check("R9 trig after high clears", trig, 1);
    v_below_ref = 1'b0;
    cycle_done = 1'b1;
    step();
    cycle_done = 1'b0;
    check("R11 duty still held", pfm_duty, 8'h5A);
    leave_pfm();
    check("R5 loop enabled", pwm_loop_dis, 0);

    // R3/R4/R6: sweep run lengths and break positions
    for (int lim = 1; lim <= 5; lim++) begin
      cfg_cycles = CW'(lim); cfg_wr = 1'b1;
      step();
      cfg_wr = 1'b0;
      for (int k = 0; k < lim; k++) begin
        for (int j = 0; j < k; j++) begin
          do_tick(8'd10);
          check("R6 run restarts after exit", pfm_mode, 0);
        end
        do_tick(THR);
        check("R3 equal current clears", pfm_mode, 0);
        pwm_duty = DW'(lim * 16 + k);
        for (int j = 1; j <= lim; j++) begin
          do_tick(j[0] ? 8'd0 : 8'd39);
          check("R4 programmed run length", pfm_mode, j == lim ? 1 : 0);
        end
        check("R11 capture per entry", pfm_duty, lim * 16 + k);
        leave_pfm();
      end
    end

    // R4: length 0 acts as 1
    cfg_cycles = '0; cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
    do_tick(8'd200);
    check("R4 zero length high tick", pfm_mode, 0);
    do_tick(8'd5);
    check("R4 zero length acts as one", pfm_mode, 1);
    leave_pfm();

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule